// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit sits beside a serial port's data path and handles the four-wire modem handshake. It holds a small control register. Software writes that register to drive the data-terminal-ready, request-to-send and two auxiliary output lines. It also presents a status byte with two parts. The upper half reports the present level of the four incoming handshake lines: clear to send, data set ready, ring indicator and carrier detect. The lower half holds sticky change flags. A flag is set by any transition of its line. The ring flag is the exception: it is set only by a high-to-low transition. The flags stay set until the status byte is read.

The incoming lines are treated as asynchronous and pass through a two-stage synchronizer. A loopback bit in the control register disconnects the external lines. The control outputs are then routed internally to the status inputs, so software can test the port without a cable. While loopback is on, the external output pins are held deasserted. Any set change flag raises a modem-status interrupt request. Prioritising that request against other sources is left to the surrounding port.

All line values are in asserted-high logic sense. Any inversion to electrical pin levels is done outside this unit.

Top module: `modem_ctl_stat`

## Requirements
- R1: A write strobe with data D loads the control register with D[4:0]. Bits 7:5 of the control read value always read 0. Bit 0 = terminal ready, bit 1 = request to send, bit 2 = aux 1, bit 3 = aux 2, bit 4 = loopback.
- R2: With loopback clear, `dtr_out`, `rts_out`, `aux1_out` and `aux2_out` follow control bits 0, 1, 2 and 3 from the cycle after the write.
- R3: With loopback clear, status bits 7:4 are {carrier detect, ring, data set ready, clear to send}. They show each external line two clock edges after it is sampled.
- R4: Status bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) are set on the edge after the reported level changes in either direction. Each stays set until a read clears it.
- R5: Status bit 2 is set only when the reported ring level goes from 1 to 0. A 0-to-1 change of ring leaves it unchanged.
- R6: A read strobe returns the flags in that cycle and clears bits 3:0 at the closing edge. A change detected at that same edge is still recorded.
- R7: With loopback set, all four output pins are 0. The external input lines are ignored. Clear to send reports control bit 1, data set ready reports bit 0, ring reports bit 2 and carrier detect reports bit 3. Changes caused by this remapping set the flags like any other change.
- R8: `msi_irq` is 1 exactly when at least one of status bits 3:0 is set.
- R9: During and right after reset, the control register, all four output pins, the status byte and `msi_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| stat_rd | input | 1 | Status read strobe; clears the change flags |
| cts_pin | input | 1 | Clear to send, asynchronous |
| dsr_pin | input | 1 | Data set ready, asynchronous |
| ri_pin | input | 1 | Ring indicator, asynchronous |
| dcd_pin | input | 1 | Carrier detect, asynchronous |
| ctl_q | output | 8 | Control register read value |
| dtr_out | output | 1 | Terminal ready drive |
| rts_out | output | 1 | Request to send drive |
| aux1_out | output | 1 | Auxiliary output 1 drive |
| aux2_out | output | 1 | Auxiliary output 2 drive |
| stat_q | output | 8 | Status read value |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that read and write strobes are sampled as single-cycle pulses. They also assume a read is the only event that may clear a change flag. They take no position on how fast the external lines move, because every line passes through the synchronizer. The stimulus therefore changes the lines at arbitrary cycles, including on the cycle a read is issued and while loopback is on. It keeps the strobes one cycle wide and applies them away from the sampling edge.

// File: rtl/modem_pkg.sv
// Shared definitions for the modem handshake unit.
// Line vectors are ordered {carrier detect, ring, data set ready, clear to send}.
package modem_pkg;
    localparam int HS_LINES = 4;
    localparam int REG_W    = 8;
    localparam int CTL_USED = 5;
    localparam int SYNC_STAGES = 2;

    // Indices into a handshake line vector
    localparam int IX_CTS = 0;
    localparam int IX_DSR = 1;
    localparam int IX_RI  = 2;
    localparam int IX_DCD = 3;

    // Indices into the control register
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX1 = 2;
    localparam int CB_AUX2 = 3;
    localparam int CB_LOOP = 4;

    // Lines whose flag is raised only on a falling edge
    localparam logic [HS_LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no coherence across bits is promised.
module hs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Each stage samples the previous one (stage 0 samples the input)
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= async_i;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/hs_delta.sv
// Sticky change detector per line. Lines marked in TRAIL set their flag
// only on a 1->0 transition; the others set on any transition.
// A clear request and a new change at the same edge leave the flag set.
module hs_delta #(
    parameter int           W     = 4,
    parameter logic [W-1:0] TRAIL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    input  logic         clr_i,
    output logic [W-1:0] delta_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_det
            if (TRAIL[i]) begin : g_fall
                // Falling-edge-only detector
                assign hit[i] = prev_q[i] & ~lines_i[i];
            end else begin : g_any
                // Either-direction detector
                assign hit[i] = prev_q[i] ^ lines_i[i];
            end
        end
    endgenerate

    // Remember last observed line levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines_i;
    end

    // Accumulate changes; a read clears only what it has already returned
    always_ff @(posedge clk) begin
        if (!rst_n) delta_o <= '0;
        else        delta_o <= (clr_i ? '0 : delta_o) | hit;
    end
endmodule

// File: rtl/modem_ctl_stat.sv
// Modem handshake control register, status byte and interrupt request.
// Assumes strobes are single-cycle and synchronous to clk; the pins are
// asynchronous and are synchronized here. Loopback bypasses the synchronizer.
module modem_ctl_stat
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             stat_rd,
    input  logic             cts_pin,
    input  logic             dsr_pin,
    input  logic             ri_pin,
    input  logic             dcd_pin,
    output logic [REG_W-1:0] ctl_q,
    output logic             dtr_out,
    output logic             rts_out,
    output logic             aux1_out,
    output logic             aux2_out,
    output logic [REG_W-1:0] stat_q,
    output logic             msi_irq
);
    logic [CTL_USED-1:0] ctl_r;
    logic [HS_LINES-1:0] pins_raw, pins_syn, loop_lines, lines_now, deltas;
    logic                loop_on;

    // Control register holds only the implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_r <= '0;
        else if (ctl_wr) ctl_r <= ctl_wdata[CTL_USED-1:0];
    end

    assign ctl_q   = {{(REG_W-CTL_USED){1'b0}}, ctl_r};
    assign loop_on = ctl_r[CB_LOOP];

    // Output drivers, silenced while looped back
    assign dtr_out  = ctl_r[CB_DTR]  & ~loop_on;
    assign rts_out  = ctl_r[CB_RTS]  & ~loop_on;
    assign aux1_out = ctl_r[CB_AUX1] & ~loop_on;
    assign aux2_out = ctl_r[CB_AUX2] & ~loop_on;

    // Gather raw pins in line-vector order
    always_comb begin
        pins_raw          = '0;
        pins_raw[IX_CTS]  = cts_pin;
        pins_raw[IX_DSR]  = dsr_pin;
        pins_raw[IX_RI]   = ri_pin;
        pins_raw[IX_DCD]  = dcd_pin;
    end

    hs_sync #(.W(HS_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_raw),
        .sync_o (pins_syn)
    );

    // Internal route from control bits to status lines
    always_comb begin
        loop_lines         = '0;
        loop_lines[IX_CTS] = ctl_r[CB_RTS];
        loop_lines[IX_DSR] = ctl_r[CB_DTR];
        loop_lines[IX_RI]  = ctl_r[CB_AUX1];
        loop_lines[IX_DCD] = ctl_r[CB_AUX2];
    end

    assign lines_now = loop_on ? loop_lines : pins_syn;

    hs_delta #(.W(HS_LINES), .TRAIL(TRAIL_ONLY)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines_i(lines_now),
        .clr_i  (stat_rd),
        .delta_o(deltas)
    );

    assign stat_q  = {lines_now, deltas};
    assign msi_irq = |deltas;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
// Property checker for modem_ctl_stat, attached by bind below.
// Assumes rst_n is synchronous and active low.
module modem_ctl_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_rd,
    input logic [7:0] ctl_q,
    input logic       dtr_out,
    input logic       rts_out,
    input logic       aux1_out,
    input logic       aux2_out,
    input logic [7:0] stat_q,
    input logic       msi_irq
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7:5] == 3'b000); // R1

    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> !(dtr_out || rts_out || aux1_out || aux2_out)); // R7

    AST_CTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !stat_rd) |=> stat_q[0]); // R4

    AST_DCD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[3] && !stat_rd) |=> stat_q[3]); // R4

    AST_RI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> (!$past(stat_q[6]) && $past(stat_q[6], 2))); // R5

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq |-> (stat_q[3:0] != 4'b0000)); // R8
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (.*);

// File: tb/tb_modem_ctl_stat.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated at each rising edge,
// compared against every output at each falling edge.
module tb_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [3:0] pins = '0;   // {dcd, ri, dsr, cts}
    logic [7:0] ctl_q, stat_q;
    logic       dtr_out, rts_out, aux1_out, aux2_out, msi_irq;

    always #2 clk = ~clk;   // 250 MHz

    modem_ctl_stat dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .cts_pin(pins[0]), .dsr_pin(pins[1]),
        .ri_pin(pins[2]), .dcd_pin(pins[3]), .ctl_q(ctl_q),
        .dtr_out(dtr_out), .rts_out(rts_out), .aux1_out(aux1_out),
        .aux2_out(aux2_out), .stat_q(stat_q), .msi_irq(msi_irq)
    );

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_ctl = '0;
    logic [3:0] m_prev = '0;
    logic [3:0] m_flag = '0;
    logic [3:0] pipe[$] = '{4'h0, 4'h0};
    bit         m_rd_last = 0;

    function automatic logic [3:0] m_lines();
        if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
        return pipe[0];
    endfunction

    always @(posedge clk) begin
        logic [3:0] now;
        if (!rst_n) begin
            m_ctl = '0; m_prev = '0; m_flag = '0;
            pipe = '{4'h0, 4'h0};
        end else begin
            now = m_lines();
            if (stat_rd) m_flag = '0;
            for (int i = 0; i < 4; i++) begin
                if (i == 2) begin
                    if (m_prev[i] && !now[i]) m_flag[i] = 1'b1;
                end else if (m_prev[i] != now[i]) m_flag[i] = 1'b1;
            end
            m_prev = now;
            if (ctl_wr) m_ctl = ctl_wdata & 8'h1F;
            void'(pipe.pop_front());
            pipe.push_back(pins);
        end
        m_rd_last = stat_rd;
        started = 1;
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            logic [3:0] ln, pin_exp;
            string tpin, tst, tfl, tri_tag;
            ln = m_lines();
            pin_exp = m_ctl[4] ? 4'h0 : m_ctl[3:0];
            tpin = !rst_n ? "R9" : (m_ctl[4] ? "R7" : "R2");
            tst  = !rst_n ? "R9" : (m_ctl[4] ? "R7" : "R3");
            tfl  = !rst_n ? "R9" : (m_rd_last ? "R6" : "R4");
            tri_tag = !rst_n ? "R9" : (m_rd_last ? "R6" : "R5");
            vectors++;
            chk(!rst_n ? "R9" : "R1", "ctl_q", ctl_q, m_ctl);
            chk(tpin, "pins", {4'h0, aux2_out, aux1_out, rts_out, dtr_out}, {4'h0, pin_exp});
            chk(tst, "levels", {4'h0, stat_q[7:4]}, {4'h0, ln});
            chk(tfl, "flags_cts_dsr_dcd", {4'h0, stat_q[3], 1'b0, stat_q[1:0]},
                {4'h0, m_flag[3], 1'b0, m_flag[1:0]});
            chk(tri_tag, "flag_ri", {7'h0, stat_q[2]}, {7'h0, m_flag[2]});
            chk(!rst_n ? "R9" : "R8", "msi_irq", {7'h0, msi_irq}, {7'h0, |m_flag});
        end
    end

    // One stimulus cycle: inputs change just after the falling edge
    task automatic step(bit wr, logic [7:0] wd, bit rd, logic [3:0] p);
        @(negedge clk); #1;
        ctl_wr = wr; ctl_wdata = wd; stat_rd = rd; pins = p;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, pins);
    endtask

    initial begin
        // R9: reset with pins asserted; state must stay cleared
        pins = 4'hF;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1; pins = 4'h0;
        idle(4);
        step(0, 0, 1, 4'h0); idle(2);
        // R1/R2: write patterns, reserved bits dropped
        step(1, 8'hE3, 0, 4'h0); idle(2);
        step(1, 8'h0C, 0, 4'h0); idle(2);
        step(1, 8'hEF, 0, 4'h0); idle(2);
        // R3/R4: each line rises then falls
        for (int b = 0; b < 4; b++) begin
            step(0, 0, 0, 4'(1 << b)); idle(4);
            step(0, 0, 1, 4'(1 << b)); idle(2);
            step(0, 0, 0, 4'h0); idle(4);
            step(0, 0, 1, 4'h0); idle(2);
        end
        // R5: ring rise alone must not flag
        step(0, 0, 0, 4'h4); idle(5);
        step(0, 0, 0, 4'h0); idle(5);
        step(0, 0, 1, 4'h0); idle(2);
        // R6: change recorded at the very edge that closes a read
        step(0, 0, 0, 4'h1); idle(1);
        step(0, 0, 1, 4'h1); idle(3);
        step(0, 0, 1, 4'h1); idle(2);
        // R7: loopback, external pins toggled and ignored
        step(1, 8'h10, 0, 4'hF); idle(3);
        step(0, 0, 1, 4'h0); idle(1);
        step(1, 8'h1F, 0, 4'hA); idle(2);
        step(1, 8'h15, 1, 4'h5); idle(2);
        step(1, 8'h1B, 0, 4'h0); idle(2);
        step(1, 8'h00, 1, 4'hF); idle(4);
        // Mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            bit w, r;
            logic [3:0] p;
            w = ($urandom % 8) == 0;
            r = ($urandom % 4) == 0;
            p = (($urandom % 4) == 0) ? 4'($urandom) : pins;
            step(w, 8'($urandom), r, p);
        end
        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule